// File: doc/BRIEF.md
# Clock Output Controller

This block owns a 16-bit control word that steers an outgoing clock pin and three companion pin options. The outgoing clock comes from a free-running divider on the main clock. Each phase of that clock lasts `HALF_PERIOD` main-clock cycles. A 2-bit mode field in the control word selects one of four settings: normal output, one of two reduced drive strengths, or output off with the pin held high. The drive strength leaves the chip as an encoded select, not as analog circuitry.

Software may rewrite the mode at any moment. The written value waits in the control word, and the applied copy takes it only at a rising edge of the outgoing clock. As a result, the pin never shows a shortened high or low phase. The three companion flags take effect one cycle after the write, and they have no timing restriction. These flags are: three-state the transmit clock pin, three-state the receive clock pin, and stop the baud generator.

The word sits on a simple single-cycle bus. The bus carries an address, a 3-bit access-space qualifier, read and write strobes, and write and read data. The read data comes back registered, one cycle after the read strobe.

Top module: `clkout_ctl`

## Requirements
- R1: While reset is high and at its release, the control word, read data, clock pin, drive select and all three flags are 0.
- R2: A write with address 0x0FA and qualifier 5 stores bits 15:11. A read with that address and qualifier returns the stored word on the read data one cycle after the strobe.
- R3: Bits 10:0 of the control word always read 0, and writing them has no effect.
- R4: A write at any other address or qualifier leaves the word unchanged. A read at any other address or qualifier returns 0.
- R5: With applied mode 00, the pin is a square wave whose level after main-clock edge k (counted from reset release) is (k / HALF_PERIOD) mod 2.
- R6: The applied mode (the drive select output) takes the stored bits 15:14 only at edges k with k mod (2*HALF_PERIOD) = HALF_PERIOD, where the pin rises. It never changes while the pin is low.
- R7: Applied mode 11 holds the pin high.
- R8: Applied modes 01 and 10 toggle the pin exactly as mode 00 does, and drive select shows the mode.
- R9: Bit 13 drives the transmit-clock three-state output, bit 12 the receive-clock three-state output and bit 11 the baud-stop output, one cycle after the write.
- R10: No high or low phase of the pin is shorter than HALF_PERIOD main-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Access address |
| bus_fc | input | 3 | Access-space qualifier |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| clk_pin | output | 1 | Outgoing clock |
| drive_sel | output | 2 | Applied mode / drive-strength select |
| txclk_hiz | output | 1 | Three-state the transmit clock pin |
| rxclk_hiz | output | 1 | Three-state the receive clock pin |
| brg_off | output | 1 | Stop the baud generator |

## Verification
Some rules hold on every cycle, and assertions check them continuously:
- the applied mode changes only with the pin high;
- the pin stays high in mode 11;
- the pin never falls in mode 11;
- the divider's high phase lasts more than one cycle;
- a missed write leaves the word alone;
- a missed read returns zero.

Other properties appear only in the bench scenarios:
- the exact phase of the square wave;
- which edge adopts a pending mode;
- the full minimum phase length after every mode-to-mode transition at every write offset;
- the read-back and masking of the word.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int WORD_W   = 16;
  localparam int MODE_LSB = 14;
  localparam int TXHZ_BIT = 13;
  localparam int RXHZ_BIT = 12;
  localparam int BRG_BIT  = 11;
  localparam int NFLAGS   = 3;

  typedef enum logic [1:0] {
    CKM_NORMAL = 2'b00,
    CKM_DRV_A  = 2'b01,
    CKM_DRV_B  = 2'b10,
    CKM_OFF    = 2'b11
  } ckmode_e;
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int           ADDR_W   = 12,
  parameter logic [11:0]  REG_ADDR = 12'h0FA,
  parameter logic [2:0]   FC_SUP   = 3'd5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2:0]          bus_fc,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output ckmode_e             mode_req,
  output logic [NFLAGS-1:0]   flags
);
  localparam int RSVD_W = BRG_BIT;

  ckmode_e           mode_q;
  logic [NFLAGS-1:0] flags_q;
  logic              hit;
  logic              rsvd_unused;

  assign hit         = (bus_addr == ADDR_W'(REG_ADDR)) && (bus_fc == FC_SUP);
  assign rsvd_unused = ^bus_wdata[RSVD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CKM_NORMAL;
      flags_q <= '0;
    end else if (bus_wr && hit) begin
      mode_q  <= ckmode_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
      flags_q <= bus_wdata[TXHZ_BIT:BRG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd && hit)
      bus_rdata <= {mode_q, flags_q, {RSVD_W{1'b0}}};
    else
      bus_rdata <= '0;
  end

  assign mode_req = mode_q;
  assign flags    = flags_q;

  AST_MISS_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst) (bus_wr && !hit) |=> ($stable(mode_q) && $stable(flags_q))); // R4
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && !hit) |=> (bus_rdata == '0)); // R4
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rd |=> (bus_rdata[RSVD_W-1:0] == '0)); // R3
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic div_next,
  output logic rise_evt
);
  localparam int CNT_W = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             div_q;
  logic             wrap;

  assign wrap     = (cnt_q == LAST);
  assign div_next = wrap ? ~div_q : div_q;
  assign rise_evt = wrap && !div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      div_q <= div_next;
    end
  end

  AST_HIGH_NOT_SINGLE: assert property (@(posedge clk) disable iff (rst) $rose(div_q) |=> div_q); // R10
  AST_LOW_NOT_SINGLE: assert property (@(posedge clk) disable iff (rst) $fell(div_q) |=> !div_q); // R10
endmodule

// File: rtl/clkout_mode_apply.sv
module clkout_mode_apply
  import clkout_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ckmode_e mode_req,
  input  logic    rise_evt,
  input  logic    div_next,
  output ckmode_e mode_applied,
  output logic    clk_pin
);
  ckmode_e mode_q;
  ckmode_e mode_nxt;
  logic    pin_q;

  assign mode_nxt = rise_evt ? mode_req : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CKM_NORMAL;
      pin_q  <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      pin_q  <= (mode_nxt == CKM_OFF) ? 1'b1 : div_next;
    end
  end

  assign mode_applied = mode_q;
  assign clk_pin      = pin_q;

  AST_CHANGE_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst) !$stable(mode_q) |-> pin_q); // R6
  AST_OFF_HOLDS_HIGH: assert property (@(posedge clk) disable iff (rst) (mode_q == CKM_OFF) |-> pin_q); // R7
  AST_NO_FALL_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) $fell(pin_q) |-> (mode_q != CKM_OFF)); // R10
endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl
  import clkout_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] REG_ADDR    = 12'h0FA,
  parameter logic [2:0]  FC_SUP      = 3'd5,
  parameter int          HALF_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_fc,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              clk_pin,
  output logic [1:0]        drive_sel,
  output logic              txclk_hiz,
  output logic              rxclk_hiz,
  output logic              brg_off
);
  ckmode_e           mode_req;
  ckmode_e           mode_applied;
  logic [NFLAGS-1:0] flags;
  logic              div_next;
  logic              rise_evt;

  clkout_regs #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .FC_SUP(FC_SUP)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_req(mode_req), .flags(flags)
  );

  clkout_divider #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk(clk), .rst(rst),
    .div_next(div_next), .rise_evt(rise_evt)
  );

  clkout_mode_apply u_apply (
    .clk(clk), .rst(rst),
    .mode_req(mode_req), .rise_evt(rise_evt), .div_next(div_next),
    .mode_applied(mode_applied), .clk_pin(clk_pin)
  );

  assign drive_sel = mode_applied;
  assign txclk_hiz = flags[2];
  assign rxclk_hiz = flags[1];
  assign brg_off   = flags[0];
endmodule

// File: tb/clkout_ctl_test.sv
module clkout_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int FULL = 2 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_fc = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        clk_pin;
  logic [1:0]  drive_sel;
  logic        txclk_hiz, rxclk_hiz, brg_off;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int total = 0;
  logic [1:0] m_mode = '0;
  logic [1:0] m_app  = '0;
  int  run_len = 1;
  logic last_pin = 1'b0;
  bit  done = 1'b0;

  clkout_ctl #(.HALF_PERIOD(HALF)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_fc(bus_fc),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_pin(clk_pin), .drive_sel(drive_sel),
    .txclk_hiz(txclk_hiz), .rxclk_hiz(rxclk_hiz), .brg_off(brg_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // Model from the requirements: edge counter, stored mode, mode adopted at rising edges (R6).
  always @(posedge clk) begin
    total <= total + 1;
    if (rst) begin
      cyc <= 0; m_mode <= 2'b00; m_app <= 2'b00;
    end else begin
      cyc <= cyc + 1;
      if (bus_wr && bus_addr == 12'h0FA && bus_fc == 3'd5) m_mode <= bus_wdata[15:14];
      if (((cyc + 1) % FULL) == HALF) m_app <= m_mode;
    end
  end

  // Continuous pin / drive-select / phase-length monitor.
  always @(negedge clk) begin
    if (rst) begin
      run_len = 1; last_pin = 1'b0;
    end else if (!done) begin
      logic exp_pin;
      exp_pin = (m_app == 2'b11) ? 1'b1 : (((cyc / HALF) % 2) == 1);
      if (m_app == 2'b11) chk(clk_pin == exp_pin, "R7 pin held high", clk_pin, exp_pin);
      else if (m_app == 2'b00) chk(clk_pin == exp_pin, "R5 square wave", clk_pin, exp_pin);
      else chk(clk_pin == exp_pin, "R8 reduced drive wave", clk_pin, exp_pin);
      chk(drive_sel == m_app, "R6 applied mode", drive_sel, m_app);
      if (clk_pin != last_pin) begin
        chk(run_len >= HALF, "R10 phase length", run_len, HALF);
        run_len = 1;
        last_pin = clk_pin;
      end else begin
        run_len++;
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [2:0] f, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_fc = f; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [2:0] f, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_fc = f; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (total > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(bus_rdata == 16'h0, "R1 rdata", bus_rdata, 0);
    chk(clk_pin == 1'b0, "R1 pin", clk_pin, 0);
    chk(drive_sel == 2'b00, "R1 drive_sel", drive_sel, 0);
    chk({txclk_hiz, rxclk_hiz, brg_off} == 3'b000, "R1 flags", {txclk_hiz, rxclk_hiz, brg_off}, 0);
    rst = 1'b0;
    bus_read(12'h0FA, 3'd5, rd);
    chk(rd == 16'h0, "R1 word after reset", rd, 0);

    // R2: read back of every combination of bits 15:11, with junk below
    for (int v = 0; v < 32; v++) begin
      bus_write(12'h0FA, 3'd5, 16'(v << 11) | 16'h02A5);
      bus_read(12'h0FA, 3'd5, rd);
      chk(rd == 16'(v << 11), "R2 read back", rd, v << 11);
    end

    // R3: reserved bits
    bus_write(12'h0FA, 3'd5, 16'hFFFF);
    bus_read(12'h0FA, 3'd5, rd);
    chk(rd == 16'hF800, "R3 all ones", rd, 16'hF800);
    bus_write(12'h0FA, 3'd5, 16'h07FF);
    bus_read(12'h0FA, 3'd5, rd);
    chk(rd == 16'h0000, "R3 reserved only", rd, 0);

    // R4: misses
    bus_write(12'h0FA, 3'd5, 16'h5000);
    bus_write(12'h0FB, 3'd5, 16'hFFFF);
    bus_write(12'h0FA, 3'd1, 16'hFFFF);
    bus_write(12'h8FA, 3'd5, 16'hFFFF);
    bus_read(12'h0FA, 3'd5, rd);
    chk(rd == 16'h5000, "R4 word unchanged", rd, 16'h5000);
    bus_read(12'h0F8, 3'd5, rd);
    chk(rd == 16'h0, "R4 wrong address reads 0", rd, 0);
    bus_read(12'h0FA, 3'd6, rd);
    chk(rd == 16'h0, "R4 wrong qualifier reads 0", rd, 0);

    // R9: flag outputs for every combination of bits 13:11
    for (int f = 0; f < 8; f++) begin
      bus_write(12'h0FA, 3'd5, 16'(f << 11));
      chk({txclk_hiz, rxclk_hiz, brg_off} == 3'(f), "R9 flag outputs", {txclk_hiz, rxclk_hiz, brg_off}, f);
    end

    // R5..R8, R10: every mode-to-mode change at every phase offset
    for (int from = 0; from < 4; from++) begin
      for (int to = 0; to < 4; to++) begin
        for (int off = 0; off < FULL; off++) begin
          bus_write(12'h0FA, 3'd5, 16'(from << 14));
          repeat (2 * FULL) @(negedge clk);
          while ((cyc % FULL) != off) @(negedge clk);
          bus_write(12'h0FA, 3'd5, 16'(to << 14));
          repeat (3 * FULL) @(negedge clk);
          chk(drive_sel == 2'(to), "R6 mode adopted", drive_sel, to);
        end
      end
    end

    bus_write(12'h0FA, 3'd5, 16'h0000);
    repeat (2 * FULL) @(negedge clk);
    finish_run();
  end
endmodule